// File: doc/BRIEF.md
# Pointer-Addressed Serial Channel Register Port

This block is the host-facing register port of one serial controller channel. The host sees only two byte addresses: a control address and a data address. Almost every register is reached through the control address in two bus cycles. The first cycle writes register 0, which loads a register pointer. The second cycle reads or writes the register that the pointer selects. After that second cycle the pointer falls back to 0, so the next control access is again a pointer write.

Register 0 also carries commands. Two small fields in the byte written to it are decoded into single-clock strobes for the neighbouring receiver, transmitter, CRC and interrupt logic. The data address is a shortcut to register 8. A write there fills the transmit holding byte, and a read returns the received character. The block holds the fifteen writable configuration bytes and presents them on a flat bus. It also multiplexes read data from status inputs supplied by the other blocks.

Top module: `sio_ctrl_port`

## Requirements
- R1: Reset sets the pointer to 0, clears all stored write registers to 0 and holds every strobe low.
- R2: A control write while the pointer is 0 loads the pointer with a 4-bit index. Bit 3 of the index is 1 only when byte bits 5:3 equal 1 ("point high"). Bits 2:0 of the index come from byte bits 2:0. The next control access reaches that index.
- R3: Any control read or write at a nonzero pointer returns the pointer to 0 after that access. Data-address accesses leave the pointer unchanged.
- R4: In a register-0 write, bits 5:3 select a command. The codes are: 2 pulses `cmd_rst_status`, 4 pulses `cmd_arm_rx_first`, 5 pulses `cmd_rst_txint`, 6 pulses `cmd_rst_rxerr` and 7 pulses `cmd_rst_ius`. Codes 0, 1 and 3 pulse nothing.
- R5: In a register-0 write, bits 7:6 select a CRC/underrun command. The codes are: 1 pulses `cmd_rst_rxcrc`, 2 pulses `cmd_rst_txcrc` and 3 pulses `cmd_rst_eom`. This field combines freely with the R4 field in the same byte.
- R6: A command strobe is high for exactly one clock, in the clock after the register-0 write edge. A write of the same byte to any other register produces no strobe.
- R7: A write to the data address, or a control write at index 8, stores the byte as register 8 (`tx_data`) and pulses `tx_load` for one clock after the edge.
- R8: A read of the data address, or a control read at index 8, returns `rx_char` on `bus_rdata` in the same cycle and pulses `rx_taken` for one clock after the edge.
- R9: Control readback is combinational from the pointer. Index 0 returns `stat_main`, index 1 returns `stat_err`, index 3 returns `stat_pend` and index 10 returns `stat_aux`. Indices 2, 12, 13 and 15 return their stored write value. Every other index returns 0.
- R10: When `bus_wr` and `bus_rd` are both high, only the write takes effect.
- R11: Stored write registers 1 to 15 appear on `cfg_regs`, with register i at bits [8i+7:8i]. Bits [7:0] read 0, and a register-0 write changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data_sel | input | 1 | 1 selects the data address, 0 the control address |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_rd | input | 1 | Read strobe for one clock |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| stat_main | input | 8 | Main status, read at index 0 |
| stat_err | input | 8 | Receive error status, read at index 1 |
| stat_pend | input | 8 | Interrupt pending flags, read at index 3 |
| stat_aux | input | 8 | Auxiliary status, read at index 10 |
| rx_char | input | 8 | Received character |
| cfg_regs | output | 128 | Stored write registers, 8 bits each |
| tx_data | output | 8 | Transmit holding byte (register 8) |
| tx_load | output | 1 | Transmit byte written strobe |
| rx_taken | output | 1 | Received character read strobe |
| cmd_rst_status | output | 1 | Status latch reset strobe |
| cmd_arm_rx_first | output | 1 | Arm interrupt on next received character |
| cmd_rst_txint | output | 1 | Transmit interrupt reset strobe |
| cmd_rst_rxerr | output | 1 | Receive error reset strobe |
| cmd_rst_ius | output | 1 | Interrupt-in-service reset strobe |
| cmd_rst_rxcrc | output | 1 | Receive CRC reset strobe |
| cmd_rst_txcrc | output | 1 | Transmit CRC reset strobe |
| cmd_rst_eom | output | 1 | Transmit underrun/end-of-message reset strobe |

## Verification
The pointer is hidden state, so it can only be seen through where the next control access lands. The awkward cases are a pointer write that also carries a command, and a data-address access slipped between a pointer write and the access it sets up. The bench reaches them by loading the pointer, then interleaving a data-address write, then proving through a readable register that the pending index survived. It also issues command codes whose bit 3 is set but which are not "point high", and shows that a following control read still returns the main status.

// File: rtl/sio_port_pkg.sv
package sio_port_pkg;

    // Byte fields of a register-0 write; positions are decoded by neighbours.
    localparam int unsigned CMD_LSB = 3;
    localparam int unsigned CMD_MSB = 5;
    localparam int unsigned CRC_LSB = 6;
    localparam int unsigned CRC_MSB = 7;

    // Register indices with fixed meaning
    localparam int unsigned IDX_MAIN = 0;
    localparam int unsigned IDX_ERR  = 1;
    localparam int unsigned IDX_PEND = 3;
    localparam int unsigned IDX_DATA = 8;
    localparam int unsigned IDX_AUX  = 10;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_POINT_HI  = 3'd1,
        OP_RST_STAT  = 3'd2,
        OP_RESERVED  = 3'd3,
        OP_ARM_RX    = 3'd4,
        OP_RST_TXINT = 3'd5,
        OP_RST_RXERR = 3'd6,
        OP_RST_IUS   = 3'd7
    } op_code_e;

    typedef enum logic [1:0] {
        CRCOP_NONE  = 2'd0,
        CRCOP_RX    = 2'd1,
        CRCOP_TX    = 2'd2,
        CRCOP_EOM   = 2'd3
    } crc_code_e;

    typedef struct packed {
        logic rst_status;
        logic arm_rx_first;
        logic rst_txint;
        logic rst_rxerr;
        logic rst_ius;
        logic rst_rxcrc;
        logic rst_txcrc;
        logic rst_eom;
    } cmd_t;

endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
    import sio_port_pkg::*;
#(
    parameter int unsigned PTRW = 4
) (
    input  logic            wr0_en,
    input  logic [7:0]      wbyte,
    output logic [PTRW-1:0] ptr_load,
    output cmd_t            cmd
);

    op_code_e  op;
    crc_code_e crc_op;

    assign op     = op_code_e'(wbyte[CMD_MSB:CMD_LSB]);
    assign crc_op = crc_code_e'(wbyte[CRC_MSB:CRC_LSB]);

    // Upper pointer bit only from the point-high code
    assign ptr_load = {(op == OP_POINT_HI), wbyte[PTRW-2:0]};

    always_comb begin
        cmd = '0;
        if (wr0_en) begin
            case (op)
                OP_RST_STAT:  cmd.rst_status   = 1'b1;
                OP_ARM_RX:    cmd.arm_rx_first = 1'b1;
                OP_RST_TXINT: cmd.rst_txint    = 1'b1;
                OP_RST_RXERR: cmd.rst_rxerr    = 1'b1;
                OP_RST_IUS:   cmd.rst_ius      = 1'b1;
                default:      ;
            endcase
            case (crc_op)
                CRCOP_RX:  cmd.rst_rxcrc = 1'b1;
                CRCOP_TX:  cmd.rst_txcrc = 1'b1;
                CRCOP_EOM: cmd.rst_eom   = 1'b1;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/sio_wreg_file.sv
module sio_wreg_file #(
    parameter int unsigned DW   = 8,
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] regs_flat
);

    // Index 0 holds commands and the pointer, not a stored byte
    assign regs_flat[DW-1:0] = '0;

    for (genvar i = 1; i < NREG; i++) begin : g_reg
        logic [DW-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_idx == IW'(i))) begin
                val_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else begin
                val_q <= val_d;
            end
        end

        assign regs_flat[i*DW +: DW] = val_q;
    end

endmodule

// File: rtl/sio_read_mux.sv
module sio_read_mux
    import sio_port_pkg::*;
#(
    parameter int unsigned DW        = 8,
    parameter int unsigned NREG      = 16,
    parameter logic [NREG-1:0] RW_MASK = NREG'(16'b1011_0000_0000_0100),
    localparam int unsigned IW       = $clog2(NREG)
) (
    input  logic               data_sel,
    input  logic [IW-1:0]      ptr,
    input  logic [NREG*DW-1:0] regs_flat,
    input  logic [DW-1:0]      stat_main,
    input  logic [DW-1:0]      stat_err,
    input  logic [DW-1:0]      stat_pend,
    input  logic [DW-1:0]      stat_aux,
    input  logic [DW-1:0]      rx_char,
    output logic [DW-1:0]      rdata
);

    logic [DW-1:0] stored;
    assign stored = regs_flat[ptr*DW +: DW];

    always_comb begin
        if (data_sel) begin
            rdata = rx_char;
        end else if (ptr == IW'(IDX_MAIN)) begin
            rdata = stat_main;
        end else if (ptr == IW'(IDX_ERR)) begin
            rdata = stat_err;
        end else if (ptr == IW'(IDX_PEND)) begin
            rdata = stat_pend;
        end else if (ptr == IW'(IDX_DATA)) begin
            rdata = rx_char;
        end else if (ptr == IW'(IDX_AUX)) begin
            rdata = stat_aux;
        end else if (RW_MASK[ptr]) begin
            rdata = stored;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/sio_ctrl_port.sv
module sio_ctrl_port
    import sio_port_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned NREG = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_data_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic [7:0]         stat_main,
    input  logic [7:0]         stat_err,
    input  logic [7:0]         stat_pend,
    input  logic [7:0]         stat_aux,
    input  logic [7:0]         rx_char,
    output logic [NREG*DW-1:0] cfg_regs,
    output logic [7:0]         tx_data,
    output logic               tx_load,
    output logic               rx_taken,
    output logic               cmd_rst_status,
    output logic               cmd_arm_rx_first,
    output logic               cmd_rst_txint,
    output logic               cmd_rst_rxerr,
    output logic               cmd_rst_ius,
    output logic               cmd_rst_rxcrc,
    output logic               cmd_rst_txcrc,
    output logic               cmd_rst_eom
);

    localparam int unsigned PTRW = $clog2(NREG);

    typedef struct packed {
        logic [PTRW-1:0] ptr;
        cmd_t            cmd;
        logic            tx_stb;
        logic            rx_stb;
    } state_t;

    state_t state_d, state_q;

    logic            ctl_wr, ctl_rd, dat_wr, dat_rd, wr0;
    logic            reg_we;
    logic [PTRW-1:0] reg_idx, ptr_load, ptr_q;
    cmd_t            dec_cmd;

    // Write has priority over a simultaneous read
    assign ctl_wr = bus_wr & ~bus_data_sel;
    assign dat_wr = bus_wr &  bus_data_sel;
    assign ctl_rd = bus_rd & ~bus_wr & ~bus_data_sel;
    assign dat_rd = bus_rd & ~bus_wr &  bus_data_sel;
    assign ptr_q  = state_q.ptr;
    assign wr0    = ctl_wr & (ptr_q == '0);

    assign reg_we  = dat_wr | (ctl_wr & (ptr_q != '0));
    assign reg_idx = dat_wr ? PTRW'(IDX_DATA) : ptr_q;

    sio_cmd_decode #(.PTRW(PTRW)) u_dec (
        .wr0_en   (wr0),
        .wbyte    (bus_wdata),
        .ptr_load (ptr_load),
        .cmd      (dec_cmd)
    );

    always_comb begin
        state_d = state_q;
        if (wr0) begin
            state_d.ptr = ptr_load;
        end else if (ctl_wr || ctl_rd) begin
            state_d.ptr = '0;
        end
        state_d.cmd    = dec_cmd;
        state_d.tx_stb = reg_we && (reg_idx == PTRW'(IDX_DATA));
        state_d.rx_stb = dat_rd || (ctl_rd && (ptr_q == PTRW'(IDX_DATA)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    sio_wreg_file #(.DW(DW), .NREG(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .wr_idx    (reg_idx),
        .wr_data   (DW'(bus_wdata)),
        .regs_flat (cfg_regs)
    );

    sio_read_mux #(.DW(8), .NREG(NREG)) u_rmux (
        .data_sel  (bus_data_sel),
        .ptr       (ptr_q),
        .regs_flat (cfg_regs),
        .stat_main (stat_main),
        .stat_err  (stat_err),
        .stat_pend (stat_pend),
        .stat_aux  (stat_aux),
        .rx_char   (rx_char),
        .rdata     (bus_rdata)
    );

    assign tx_data          = cfg_regs[IDX_DATA*DW +: 8];
    assign tx_load          = state_q.tx_stb;
    assign rx_taken         = state_q.rx_stb;
    assign cmd_rst_status   = state_q.cmd.rst_status;
    assign cmd_arm_rx_first = state_q.cmd.arm_rx_first;
    assign cmd_rst_txint    = state_q.cmd.rst_txint;
    assign cmd_rst_rxerr    = state_q.cmd.rst_rxerr;
    assign cmd_rst_ius      = state_q.cmd.rst_ius;
    assign cmd_rst_rxcrc    = state_q.cmd.rst_rxcrc;
    assign cmd_rst_txcrc    = state_q.cmd.rst_txcrc;
    assign cmd_rst_eom      = state_q.cmd.rst_eom;

endmodule

// File: rtl/sio_ctrl_port_chk.sv
module sio_ctrl_port_chk #(
    parameter int unsigned NREG = 16,
    localparam int unsigned PTRW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_data_sel,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [PTRW-1:0] ptr,
    input logic            cmd_any,
    input logic            tx_stb,
    input logic            rx_stb,
    input logic [7:0]      rdata,
    input logic [7:0]      stat_main
);

    a_r3_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_data_sel && (bus_wr || bus_rd) && ptr != '0) |=> (ptr == '0));

    a_r3_data_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_sel && (bus_wr || bus_rd)) |=> $stable(ptr));

    a_r6_cmd_from_wr0: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |-> $past(bus_wr && !bus_data_sel && ptr == '0));

    a_r7_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> $past(bus_wr && (bus_data_sel || ptr == PTRW'(8))));

    a_r8_rx_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |-> $past(bus_rd && !bus_wr && (bus_data_sel || ptr == PTRW'(8))));

    a_r9_main_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_data_sel && ptr == '0) |-> (rdata == stat_main));

endmodule

bind sio_ctrl_port sio_ctrl_port_chk #(.NREG(NREG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_data_sel (bus_data_sel),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .ptr          (ptr_q),
    .cmd_any      (|state_q.cmd),
    .tx_stb       (tx_load),
    .rx_stb       (rx_taken),
    .rdata        (bus_rdata),
    .stat_main    (stat_main)
);

// File: tb/sio_ctrl_port_test.sv
module sio_ctrl_port_test;

    localparam logic [7:0] MAIN = 8'hA5, ERR = 8'h3C, PEND = 8'h21;
    localparam logic [7:0] AUX = 8'h6E, RXC = 8'hD7;

    logic         clk = 0, rst_n = 0;
    logic         bus_data_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0]   bus_wdata = 0, bus_rdata, tx_data;
    logic [127:0] cfg_regs;
    logic         tx_load, rx_taken;
    logic         c_st, c_arm, c_txi, c_rxe, c_ius, c_rxc, c_txc, c_eom;
    logic [7:0]   cmdv;
    int           checks = 0, errors = 0;
    bit           done = 0;

    always #5 clk = ~clk;
    assign cmdv = {c_st, c_arm, c_txi, c_rxe, c_ius, c_rxc, c_txc, c_eom};

    sio_ctrl_port uut (
        .clk(clk), .rst_n(rst_n), .bus_data_sel(bus_data_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_main(MAIN), .stat_err(ERR), .stat_pend(PEND), .stat_aux(AUX),
        .rx_char(RXC), .cfg_regs(cfg_regs), .tx_data(tx_data), .tx_load(tx_load),
        .rx_taken(rx_taken), .cmd_rst_status(c_st), .cmd_arm_rx_first(c_arm),
        .cmd_rst_txint(c_txi), .cmd_rst_rxerr(c_rxe), .cmd_rst_ius(c_ius),
        .cmd_rst_rxcrc(c_rxc), .cmd_rst_txcrc(c_txc), .cmd_rst_eom(c_eom)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected strobes {status,arm,txint,rxerr,ius,rxcrc,txcrc,eom} (R4, R5)
    function automatic logic [7:0] exp_cmd(input logic [7:0] b);
        logic [7:0] v = 0;
        case (b[5:3])
            3'd2: v[7] = 1; 3'd4: v[6] = 1; 3'd5: v[5] = 1;
            3'd6: v[4] = 1; 3'd7: v[3] = 1; default: ;
        endcase
        case (b[7:6])
            2'd1: v[2] = 1; 2'd2: v[1] = 1; 2'd3: v[0] = 1; default: ;
        endcase
        return v;
    endfunction

    // Control write, checks strobes after the edge and that they last one clock
    task automatic ctl_write(input logic [7:0] v, input logic [7:0] exp_strb, input string req);
        @(negedge clk); bus_data_sel = 0; bus_wr = 1; bus_wdata = v;
        @(negedge clk); bus_wr = 0;
        check(cmdv == exp_strb, req, cmdv, exp_strb);
        @(negedge clk);
        check(cmdv == 0, {req, " one-clock R6"}, cmdv, 0);
    endtask

    task automatic rd(input bit dsel, output logic [7:0] v);
        @(negedge clk); bus_data_sel = dsel; bus_rd = 1;
        #1 v = bus_rdata;
        @(negedge clk); bus_rd = 0; bus_data_sel = 0;
    endtask

    function automatic logic [7:0] cfg(input int i);
        return cfg_regs[i*8 +: 8];
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        check(cfg_regs == 0, "R1 cfg cleared", cfg_regs, 0);
        check({cmdv, tx_load, rx_taken} == 0, "R1 strobes low", {cmdv, tx_load, rx_taken}, 0);
        rd(0, v);
        check(v == MAIN, "R1 pointer zero", v, MAIN);
    endtask

    task automatic t_rw_reg();
        logic [7:0] v;
        ctl_write(8'h0C, 0, "R2 point-high to 12");
        ctl_write(8'h5A, 0, "R11 write reg12");
        check(cfg(12) == 8'h5A, "R11 cfg reg12", cfg(12), 8'h5A);
        ctl_write(8'h0C, 0, "R2 point 12");
        rd(0, v);
        check(v == 8'h5A, "R9 readback reg12", v, 8'h5A);
        rd(0, v);
        check(v == MAIN, "R3 pointer home after read", v, MAIN);
    endtask

    task automatic t_write_only();
        logic [7:0] v;
        ctl_write(8'h05, 0, "R2 point 5");
        ctl_write(8'hFF, 0, "R11 write reg5");
        check(cfg(5) == 8'hFF, "R11 cfg reg5", cfg(5), 8'hFF);
        ctl_write(8'h05, 0, "R2 point 5");
        rd(0, v);
        check(v == 0, "R9 write-only reads zero", v, 0);
        ctl_write(8'h00, 0, "R11 reg0 write");
        check(cfg(0) == 0 && cfg(5) == 8'hFF, "R11 reg0 stores nothing", cfg(5), 8'hFF);
    endtask

    task automatic t_status_reads();
        logic [7:0] v;
        ctl_write(8'h01, 0, "R2 point 1"); rd(0, v);
        check(v == ERR, "R9 index1", v, ERR);
        ctl_write(8'h03, 0, "R2 point 3"); rd(0, v);
        check(v == PEND, "R9 index3", v, PEND);
        ctl_write(8'h0A, 0, "R2 point 10"); rd(0, v);
        check(v == AUX, "R9 index10", v, AUX);
    endtask

    task automatic t_commands();
        logic [7:0] v;
        for (int c = 0; c < 8; c++) begin
            if (c == 1) continue;
            ctl_write(8'(c << 3), exp_cmd(8'(c << 3)), "R4 command code");
            rd(0, v);
            check(v == MAIN, "R2 command leaves pointer 0", v, MAIN);
        end
        for (int k = 1; k < 4; k++) begin
            ctl_write(8'(k << 6), exp_cmd(8'(k << 6)), "R5 crc code");
        end
        ctl_write(8'hD0, 8'h81, "R5 combined with R4");
        ctl_write(8'h08, 0, "R2 point-high no strobe");
        rd(0, v);
        check(v == RXC, "R2 point-high reaches 8", v, RXC);
    endtask

    task automatic t_no_cmd_elsewhere();
        ctl_write(8'h04, 0, "R2 point 4");
        ctl_write(8'hF8, 0, "R6 no strobe off reg0");
        check(cfg(4) == 8'hF8, "R6 reg4 stored", cfg(4), 8'hF8);
    endtask

    task automatic t_data_port();
        logic [7:0] v;
        ctl_write(8'h02, 0, "R2 point 2");
        @(negedge clk); bus_data_sel = 1; bus_wr = 1; bus_wdata = 8'h3C;
        @(negedge clk); bus_wr = 0; bus_data_sel = 0;
        check(tx_load == 1 && tx_data == 8'h3C, "R7 data write", {tx_load, tx_data}, 9'h13C);
        @(negedge clk);
        check(tx_load == 0, "R7 tx strobe one clock", tx_load, 0);
        @(negedge clk); bus_data_sel = 1; bus_rd = 1;
        #1 v = bus_rdata;
        @(negedge clk); bus_rd = 0; bus_data_sel = 0;
        check(v == RXC && rx_taken == 1, "R8 data read", {rx_taken, v}, {1'b1, RXC});
        @(negedge clk);
        check(rx_taken == 0, "R8 rx strobe one clock", rx_taken, 0);
        ctl_write(8'h77, 0, "R3 pointer kept over data access");
        check(cfg(2) == 8'h77, "R3 reg2 reached", cfg(2), 8'h77);
        ctl_write(8'h08, 0, "R2 point 8");
        @(negedge clk); bus_wr = 1; bus_wdata = 8'h91;
        @(negedge clk); bus_wr = 0;
        check(tx_load == 1 && tx_data == 8'h91, "R7 control write at 8", tx_data, 8'h91);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        ctl_write(8'h0D, 0, "R2 point 13");
        @(negedge clk); bus_wr = 1; bus_rd = 1; bus_wdata = 8'h99;
        @(negedge clk); bus_wr = 0; bus_rd = 0;
        check(cfg(13) == 8'h99, "R10 write wins", cfg(13), 8'h99);
        rd(0, v);
        check(v == MAIN, "R10 R3 pointer home", v, MAIN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rw_reg();
        t_write_only();
        t_status_reads();
        t_commands();
        t_no_cmd_elsewhere();
        t_data_port();
        t_priority();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule